// File: doc/BRIEF.md
# Multi-File Rename Mapping Tracker

This block keeps occupancy counts for a set of rename register files in an out-of-order core's dispatch stage. Every architectural register belongs to file 0, the unified file, and to at most one further file chosen from a per-register table set by a parameter. The secondary files never share a register. When an instruction is dispatched, its destination registers each take one mapping in every file that holds them. When an older write is invalidated, the same files get those mappings back.

Allocation requests use a valid/ready handshake. The destination set presented on the allocate pins is checked combinationally against every file. The result is a stall mask with one bit per file, and a 1 marks a file that cannot take the request. `alloc_ready` is high only when the whole mask is zero. A request is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. The requester may hold `alloc_valid` high while `alloc_ready` is low and may change the request during that time. Releases have no back-pressure: a cycle with `rel_valid` high always takes effect. A file whose capacity parameter is zero has no limit.

Top module: `rename_map_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every used count to zero.
- R2: Every register maps to file 0. The 2-bit field at bits [2i+1:2i] of `REG_SEL` names the secondary file of register i. A value of 0, or a value of `NUM_FILES` or more, means the register has no secondary file. With the defaults, registers 0–7 map to file 1, registers 8–13 map to file 2, and registers 14–15 map to file 0 only.
- R3: A file with capacity 0 is unbounded. Its stall bit is never set and its used count always reads 0.
- R4: Stall bit k is 1 exactly when capacity k is nonzero and used_k plus requested_k is greater than capacity k. requested_k is the number of enabled allocate slots whose register lies in file k, and a register named twice counts twice. The mask does not depend on `alloc_valid`. A request that fills a file exactly to its capacity does not stall.
- R5: `alloc_ready` equals the stall mask being all zero. An accepted request adds requested_k to used_k in the next cycle.
- R6: A release (`rel_valid` high) subtracts from each file the number of enabled release slots whose register lies in that file. An accepted allocate and a release in the same cycle are both applied.
- R7: A release larger than a file's used count leaves that count at zero. The excess is ignored.
- R8: The stall mask takes no account of a release in the same cycle.
- R9: An allocate that is not accepted (`alloc_valid` high, `alloc_ready` low) leaves every count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocate request present |
| alloc_ready | output | 1 | Every file can take the presented request |
| alloc_dst_en | input | DEST | Per-slot enable of destination registers |
| alloc_dst_reg | input | DEST*REG_W | Destination register indices, slot s at [s*REG_W +: REG_W] |
| rel_valid | input | 1 | Release request, always accepted |
| rel_dst_en | input | DEST | Per-slot enable of released registers |
| rel_dst_reg | input | DEST*REG_W | Released register indices |
| stall_mask | output | NUM_FILES | Bit k set when file k lacks room for the request |
| used_cnt | output | NUM_FILES*CNT_W | Used count of file k at [k*CNT_W +: CNT_W] |

## Verification
The two functions that can fall in the same cycle are an accepted allocate and a release. Directed steps drive both on one cycle while a file is full, and then again with one free entry. The first case shows that the stall ignores the concurrent release and that the release still applies. The second shows that both updates land together. Random steps then mix both operations freely, and a bench model computes each file's next count as saturate-at-zero of used plus accepted minus released.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  localparam int unsigned RMT_SEL_W = 2;

  // number of set bits in a request slot vector (up to 32 slots)
  function automatic int unsigned rmt_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/rmt_reg_decode.sv
module rmt_reg_decode #(
  parameter int NUM_ARCH  = 16,
  parameter int NUM_FILES = 3,
  parameter int SEL_W     = rmt_pkg::RMT_SEL_W,
  parameter logic [NUM_ARCH*SEL_W-1:0] REG_SEL = '0,
  localparam int REG_W    = $clog2(NUM_ARCH)
) (
  input  logic [REG_W-1:0]     reg_idx,
  output logic [NUM_FILES-1:0] file_mask
);
  logic [SEL_W-1:0] sel;

  always_comb begin
    sel       = REG_SEL[reg_idx*SEL_W +: SEL_W];
    file_mask = '0;
    file_mask[0] = 1'b1;  // unified file sees every register
    for (int f = 1; f < NUM_FILES; f++)
      if (int'(sel) == f) file_mask[f] = 1'b1;
  end
endmodule

// File: rtl/rmt_file_counter.sv
module rmt_file_counter #(
  parameter int CNT_W = 4,
  parameter int DEST  = 2,
  parameter logic [CNT_W-1:0] CAP = '0,
  localparam int SUM_W   = CNT_W + $clog2(DEST + 1) + 1,
  localparam bit BOUNDED = (CAP != '0)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [DEST-1:0]  alloc_hit,
  input  logic [DEST-1:0]  rel_hit,
  output logic [CNT_W-1:0] used,
  output logic             stall
);
  logic [SUM_W-1:0] req, relc, base, nxt;
  logic [CNT_W-1:0] used_q;

  always_comb begin
    req   = SUM_W'(rmt_pkg::rmt_ones(32'(alloc_hit)));
    relc  = SUM_W'(rmt_pkg::rmt_ones(32'(rel_hit)));
    stall = BOUNDED && ((SUM_W'(used_q) + req) > SUM_W'(CAP));
    base  = fire ? SUM_W'(used_q) + req : SUM_W'(used_q);
    nxt   = (relc > base) ? '0 : base - relc;
  end

  always_ff @(posedge clk) begin
    if (rst || !BOUNDED) used_q <= '0;
    else                 used_q <= nxt[CNT_W-1:0];
  end

  assign used = used_q;
endmodule

// File: rtl/rename_map_tracker.sv
module rename_map_tracker #(
  parameter int NUM_ARCH  = 16,
  parameter int NUM_FILES = 3,
  parameter int DEST      = 2,
  parameter int CNT_W     = 4,
  parameter int SEL_W     = rmt_pkg::RMT_SEL_W,
  parameter logic [NUM_FILES*CNT_W-1:0] FILE_CAP = 12'h460,
  parameter logic [NUM_ARCH*SEL_W-1:0]  REG_SEL  = 32'h0AAA_5555,
  localparam int REG_W = $clog2(NUM_ARCH)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       alloc_valid,
  output logic                       alloc_ready,
  input  logic [DEST-1:0]            alloc_dst_en,
  input  logic [DEST*REG_W-1:0]      alloc_dst_reg,
  input  logic                       rel_valid,
  input  logic [DEST-1:0]            rel_dst_en,
  input  logic [DEST*REG_W-1:0]      rel_dst_reg,
  output logic [NUM_FILES-1:0]       stall_mask,
  output logic [NUM_FILES*CNT_W-1:0] used_cnt
);
  logic [NUM_FILES-1:0] a_mask [DEST];
  logic [NUM_FILES-1:0] r_mask [DEST];
  logic [DEST-1:0]      a_hit  [NUM_FILES];
  logic [DEST-1:0]      r_hit  [NUM_FILES];
  logic                 fire;

  for (genvar s = 0; s < DEST; s++) begin : g_slot
    rmt_reg_decode #(
      .NUM_ARCH(NUM_ARCH), .NUM_FILES(NUM_FILES), .SEL_W(SEL_W), .REG_SEL(REG_SEL)
    ) i_dec_alloc (
      .reg_idx(alloc_dst_reg[s*REG_W +: REG_W]), .file_mask(a_mask[s])
    );
    rmt_reg_decode #(
      .NUM_ARCH(NUM_ARCH), .NUM_FILES(NUM_FILES), .SEL_W(SEL_W), .REG_SEL(REG_SEL)
    ) i_dec_rel (
      .reg_idx(rel_dst_reg[s*REG_W +: REG_W]), .file_mask(r_mask[s])
    );
  end

  assign fire = alloc_valid && alloc_ready;

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    for (genvar s = 0; s < DEST; s++) begin : g_hit
      assign a_hit[f][s] = alloc_dst_en[s] && a_mask[s][f];
      assign r_hit[f][s] = rel_valid && rel_dst_en[s] && r_mask[s][f];
    end
    rmt_file_counter #(
      .CNT_W(CNT_W), .DEST(DEST), .CAP(FILE_CAP[f*CNT_W +: CNT_W])
    ) i_cnt (
      .clk(clk), .rst(rst), .fire(fire),
      .alloc_hit(a_hit[f]), .rel_hit(r_hit[f]),
      .used(used_cnt[f*CNT_W +: CNT_W]), .stall(stall_mask[f])
    );
  end

  assign alloc_ready = (stall_mask == '0);
endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int NUM_FILES = 3,
  parameter int CNT_W     = 4,
  parameter logic [NUM_FILES*CNT_W-1:0] FILE_CAP = '0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       alloc_valid,
  input logic                       alloc_ready,
  input logic                       rel_valid,
  input logic [NUM_FILES-1:0]       stall_mask,
  input logic [NUM_FILES*CNT_W-1:0] used_cnt
);
  logic fire;
  assign fire = alloc_valid && alloc_ready;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> used_cnt == '0);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!fire && !rel_valid) |=> $stable(used_cnt));

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_chk
    localparam logic [CNT_W-1:0] CAP = FILE_CAP[f*CNT_W +: CNT_W];
    if (CAP == '0) begin : g_unb
      a_r3_unbounded: assert property (@(posedge clk) disable iff (rst)
        (used_cnt[f*CNT_W +: CNT_W] == '0) && !stall_mask[f]);
    end else begin : g_bnd
      a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        used_cnt[f*CNT_W +: CNT_W] <= CAP);
    end
    a_r5_alloc_grows: assert property (@(posedge clk) disable iff (rst)
      (fire && !rel_valid) |=> used_cnt[f*CNT_W +: CNT_W] >= $past(used_cnt[f*CNT_W +: CNT_W]));
    a_r7_rel_shrinks: assert property (@(posedge clk) disable iff (rst)
      (rel_valid && !fire) |=> used_cnt[f*CNT_W +: CNT_W] <= $past(used_cnt[f*CNT_W +: CNT_W]));
  end
endmodule

bind rename_map_tracker rmt_checker #(
  .NUM_FILES(NUM_FILES), .CNT_W(CNT_W), .FILE_CAP(FILE_CAP)
) i_rmt_checker (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .rel_valid(rel_valid), .stall_mask(stall_mask), .used_cnt(used_cnt)
);

// File: tb/test_rename_map_tracker.sv
`timescale 1ns/1ps
module test_rename_map_tracker;
  localparam int NF = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 1'b0, rel_valid = 1'b0;
  logic alloc_ready;
  logic [1:0] alloc_dst_en = '0, rel_dst_en = '0;
  logic [7:0] alloc_dst_reg = '0, rel_dst_reg = '0;
  logic [NF-1:0] stall_mask;
  logic [NF*CW-1:0] used_cnt;

  int n_tests = 0, n_fail = 0;
  int cap[NF] = '{0, 6, 4};
  int used_m[NF] = '{0, 0, 0};

  always #2.5 clk = ~clk;

  rename_map_tracker i_rename_map_tracker (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_dst_en(alloc_dst_en), .alloc_dst_reg(alloc_dst_reg),
    .rel_valid(rel_valid), .rel_dst_en(rel_dst_en), .rel_dst_reg(rel_dst_reg),
    .stall_mask(stall_mask), .used_cnt(used_cnt)
  );

  // secondary file of a register, from R2 with the default table
  function automatic int home(input int r);
    if (r < 8) return 1;
    if (r < 14) return 2;
    return 0;
  endfunction

  function automatic int req_in(input int f, input logic [1:0] en, input int r0, input int r1);
    int n = 0;
    if (en[0] && (f == 0 || home(r0) == f)) n++;
    if (en[1] && (f == 0 || home(r1) == f)) n++;
    return n;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_counts(input string tag);
    for (int f = 0; f < NF; f++)
      chk(tag, $sformatf("used file %0d", f), int'(used_cnt[f*CW +: CW]), used_m[f]);
  endtask

  // one cycle: drive, check combinational outputs, clock, check counts
  task automatic step(input logic av, input logic [1:0] aen, input int a0, input int a1,
                      input logic rv, input logic [1:0] ren, input int r0, input int r1,
                      input string tag);
    int exp_mask;
    int nxt[NF];
    bit rdy;
    alloc_valid = av; alloc_dst_en = aen;
    alloc_dst_reg = {4'(a1), 4'(a0)};
    rel_valid = rv; rel_dst_en = ren;
    rel_dst_reg = {4'(r1), 4'(r0)};
    #1;
    exp_mask = 0;
    for (int f = 0; f < NF; f++)
      if (cap[f] != 0 && used_m[f] + req_in(f, aen, a0, a1) > cap[f]) exp_mask |= (1 << f);
    rdy = (exp_mask == 0);
    chk(tag, "stall_mask", int'(stall_mask), exp_mask);
    chk(tag, "alloc_ready", int'(alloc_ready), int'(rdy));
    for (int f = 0; f < NF; f++) begin
      nxt[f] = used_m[f] + ((av && rdy) ? req_in(f, aen, a0, a1) : 0);
      if (rv) nxt[f] -= req_in(f, ren, r0, r1);
      if (nxt[f] < 0) nxt[f] = 0;
      if (cap[f] == 0) nxt[f] = 0;
    end
    @(posedge clk); #1;
    for (int f = 0; f < NF; f++) used_m[f] = nxt[f];
    check_counts(tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: counts clear out of reset
    check_counts("R1");
    chk("R1", "stall_mask", int'(stall_mask), 0);
    // R5: fill file 1 to exactly its capacity
    step(1, 2'b11, 0, 1, 0, 2'b00, 0, 0, "R5");
    step(1, 2'b11, 2, 3, 0, 2'b00, 0, 0, "R5");
    step(1, 2'b11, 4, 5, 0, 2'b00, 0, 0, "R5");
    // R3: unbounded file 0 still reads zero
    chk("R3", "used file0", int'(used_cnt[0 +: CW]), 0);
    // R4 and R9: one more entry for file 1 stalls with mask 0b010
    step(1, 2'b01, 6, 0, 0, 2'b00, 0, 0, "R9");
    chk("R4", "full mask", int'(stall_mask), 2);
    // R8: release of the same cycle does not lift the stall, release applies (R6)
    step(1, 2'b01, 6, 0, 1, 2'b01, 0, 0, "R8");
    // R6: now one free entry, allocate and release land together
    step(1, 2'b01, 6, 0, 1, 2'b01, 1, 0, "R6");
    // R2: register 14 lies in file 0 only; file 2 unaffected
    step(1, 2'b11, 14, 15, 0, 2'b00, 0, 0, "R2");
    // R7: releasing from empty file 2 stays at zero
    step(0, 2'b00, 0, 0, 1, 2'b11, 8, 9, "R7");
    // R4: duplicate register counts twice
    step(1, 2'b11, 8, 8, 0, 2'b00, 0, 0, "R4");
    step(1, 2'b11, 9, 10, 0, 2'b00, 0, 0, "R4");
    step(1, 2'b01, 11, 0, 0, 2'b00, 0, 0, "R4");
    // random mix of both operations
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           $urandom_range(0, 15), $urandom_range(0, 15),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           $urandom_range(0, 15), $urandom_range(0, 15), "R6");
    end
    // R1: reset in mid run clears counts
    rst = 1'b1; alloc_valid = 1'b0; rel_valid = 1'b0;
    @(posedge clk); #1 rst = 1'b0;
    for (int f = 0; f < NF; f++) used_m[f] = 0;
    check_counts("R1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule